// File: doc/BRIEF.md
# External Bus Request/Grant Arbiter

This block decides who drives a shared external memory bus. Internal traffic from the processor core and from DMA-capable peripherals owns the bus by default. An outside master may ask for the bus through an asynchronous request line. That request is honoured only when no internal access is pending, so it always has the lowest priority.

Before the grant goes out, the block turns off its own drivers for the address, data, select and strobe lines. When the outside master drops its request, the block withdraws the grant and then turns its drivers back on. While the bus is away, the block stalls any core access to the external spaces. A hold-off flag reports any internal requester that is waiting on the bus.

The core can mark the two reads of one instruction as an atomic pair, and the bus is never handed over between them. The gap between a read and a following write carries no such mark, so a grant can fall inside it. A configuration input reserves the interface for internal use only.

Top module: `ext_bus_arbiter`

## Requirements
- R1: While rst_ni is low, and after its release, the outputs are as follows until a request arrives: ext_gnt_o=0, drv_en_o=1, core_stall_o=0 and gnt_holdoff_o=0.
- R2: Let k be the first clock edge at which ext_req_i is high, with no internal request pending and exclusive mode off. drv_en_o goes low after edge k+2, and ext_gnt_o goes high after edge k+3, not earlier.
- R3: drv_en_o is low for at least one full cycle before ext_gnt_o rises.
- R4: ext_gnt_o does not rise while core_req_i or dma_req_i is high. Once both are low at an edge where the synchronized request is high, drv_en_o drops after that edge and ext_gnt_o rises one edge later.
- R5: While pair_lock_i is high, the grant is withheld even if core_req_i and dma_req_i are both low. A request-free gap with pair_lock_i low, such as the gap between a read and a write, lets the grant through as in R4.
- R6: core_stall_o equals core_req_i while drv_en_o is low and is 0 otherwise. gnt_holdoff_o equals (core_req_i or dma_req_i) while drv_en_o is low and is 0 otherwise. Both follow their inputs within the same cycle.
- R7: A grant that has been given stays high while the synchronized request stays high, whatever the internal requests do.
- R8: Let m be the first edge at which ext_req_i is low during a grant. ext_gnt_o goes low after edge m+2, and drv_en_o returns high after edge m+3.
- R9: While excl_mode_i is high, ext_gnt_o never rises and drv_en_o stays high when it was high.
- R10: An internal request seen at the edge that ends the drivers-off cycle cancels the handover. ext_gnt_o stays low and drv_en_o is high again after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Arbiter clock |
| rst_ni | input | 1 | Active-low reset of the arbiter only |
| ext_req_i | input | 1 | Asynchronous bus request from the outside master |
| core_req_i | input | 1 | Core wants an external access this cycle |
| dma_req_i | input | 1 | A DMA peripheral wants an external access this cycle |
| pair_lock_i | input | 1 | Core is between the two reads of an atomic pair |
| excl_mode_i | input | 1 | Reserve the bus for internal requesters only |
| ext_gnt_o | output | 1 | Bus granted to the outside master |
| drv_en_o | output | 1 | Enable for address, data, select and strobe drivers |
| gnt_holdoff_o | output | 1 | An internal requester is waiting on the granted bus |
| core_stall_o | output | 1 | Core access stalled because the bus is away |

## Verification
Directed sequences first drive a lone request on an idle bus, which measures the exact handover and release latencies. The request is then held against core or DMA traffic and against the pair lock, showing that the grant waits on every internal source and resumes as soon as they clear. Further cases raise internal requests during the drivers-off cycle and during a grant, which separates a cancelled handover from a grant that must not be revoked. Exclusive mode is checked to block an otherwise grantable request. A long random mix of toggling requests, locks and mode changes is compared every cycle against a bench model of the requirements, to catch ordering faults that the directed cases miss.

// File: rtl/ext_arb_pkg.sv
package ext_arb_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE    = 2'd0,
        ARB_FLOAT   = 2'd1,
        ARB_GRANTED = 2'd2,
        ARB_RETURN  = 2'd3
    } arb_state_e;

    typedef struct packed {
        arb_state_e st;
        logic       gnt;
        logic       drv_en;
    } arb_regs_t;

endpackage

// File: rtl/ext_req_sync.sv
module ext_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = async_i;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], async_i};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/ext_grant_fsm.sv
module ext_grant_fsm
    import ext_arb_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_sync_i,
    input  logic int_pend_i,
    input  logic excl_i,
    output logic gnt_o,
    output logic drv_en_o
);
    arb_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ARB_IDLE: begin
                if (req_sync_i && !int_pend_i && !excl_i) r_d.st = ARB_FLOAT;
            end
            ARB_FLOAT: begin
                // drivers are off this cycle; grant only if still clear
                if (req_sync_i && !int_pend_i && !excl_i) r_d.st = ARB_GRANTED;
                else                                      r_d.st = ARB_IDLE;
            end
            ARB_GRANTED: begin
                // never revoked by internal traffic
                if (!req_sync_i) r_d.st = ARB_RETURN;
            end
            default: begin
                r_d.st = ARB_IDLE;
            end
        endcase
        r_d.gnt    = (r_d.st == ARB_GRANTED);
        r_d.drv_en = (r_d.st == ARB_IDLE);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.st     <= ARB_IDLE;
            r_q.gnt    <= 1'b0;
            r_q.drv_en <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign gnt_o    = r_q.gnt;
    assign drv_en_o = r_q.drv_en;
endmodule

// File: rtl/ext_access_gate.sv
module ext_access_gate (
    input  logic core_req_i,
    input  logic dma_req_i,
    input  logic bus_away_i,
    output logic core_stall_o,
    output logic holdoff_o
);
    assign core_stall_o = core_req_i & bus_away_i;
    assign holdoff_o    = (core_req_i | dma_req_i) & bus_away_i;
endmodule

// File: rtl/ext_bus_arbiter.sv
module ext_bus_arbiter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ext_req_i,
    input  logic core_req_i,
    input  logic dma_req_i,
    input  logic pair_lock_i,
    input  logic excl_mode_i,
    output logic ext_gnt_o,
    output logic drv_en_o,
    output logic gnt_holdoff_o,
    output logic core_stall_o
);
    logic req_sync;
    logic int_pend;

    assign int_pend = core_req_i | dma_req_i | pair_lock_i;

    ext_req_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (ext_req_i),
        .sync_o  (req_sync)
    );

    ext_grant_fsm i_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .req_sync_i (req_sync),
        .int_pend_i (int_pend),
        .excl_i     (excl_mode_i),
        .gnt_o      (ext_gnt_o),
        .drv_en_o   (drv_en_o)
    );

    ext_access_gate i_gate (
        .core_req_i   (core_req_i),
        .dma_req_i    (dma_req_i),
        .bus_away_i   (!drv_en_o),
        .core_stall_o (core_stall_o),
        .holdoff_o    (gnt_holdoff_o)
    );
endmodule

// File: rtl/ext_bus_arbiter_chk.sv
module ext_bus_arbiter_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic core_req_i,
    input logic dma_req_i,
    input logic pair_lock_i,
    input logic excl_mode_i,
    input logic req_sync,
    input logic ext_gnt_o,
    input logic drv_en_o,
    input logic gnt_holdoff_o,
    input logic core_stall_o
);
    AST_FLOAT_BEFORE_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ext_gnt_o) |-> !$past(drv_en_o)); // R3

    AST_INTERNAL_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ext_gnt_o && (core_req_i || dma_req_i || pair_lock_i)) |=> !ext_gnt_o); // R4

    AST_STALL_ONLY_AWAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (core_stall_o || gnt_holdoff_o) |-> !drv_en_o); // R6

    AST_NO_REVOKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ext_gnt_o && req_sync) |=> ext_gnt_o); // R7

    AST_DRIVERS_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ext_gnt_o) |=> drv_en_o); // R8

    AST_EXCL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (excl_mode_i && drv_en_o) |=> drv_en_o); // R9
endmodule

bind ext_bus_arbiter ext_bus_arbiter_chk i_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .core_req_i    (core_req_i),
    .dma_req_i     (dma_req_i),
    .pair_lock_i   (pair_lock_i),
    .excl_mode_i   (excl_mode_i),
    .req_sync      (req_sync),
    .ext_gnt_o     (ext_gnt_o),
    .drv_en_o      (drv_en_o),
    .gnt_holdoff_o (gnt_holdoff_o),
    .core_stall_o  (core_stall_o)
);

// File: tb/test_ext_bus_arbiter.sv
module test_ext_bus_arbiter;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_req = 0, core_req = 0, dma_req = 0, pair_lock = 0, excl = 0;
    logic gnt, drv_en, holdoff, stall;
    int checks = 0, failures = 0, cycles = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_bus_arbiter i_ext_bus_arbiter (
        .clk_i(clk), .rst_ni(rst_n), .ext_req_i(ext_req), .core_req_i(core_req),
        .dma_req_i(dma_req), .pair_lock_i(pair_lock), .excl_mode_i(excl),
        .ext_gnt_o(gnt), .drv_en_o(drv_en), .gnt_holdoff_o(holdoff), .core_stall_o(stall)
    );

    // reference model built from the requirements: 0 idle, 1 float, 2 granted, 3 return
    logic m_s1, m_s2;
    int   m_st;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_st <= 0;
        end else begin
            m_s1 <= ext_req;
            m_s2 <= m_s1;
            case (m_st)
                0: if (m_s2 && !(core_req || dma_req || pair_lock) && !excl) m_st <= 1;
                1: m_st <= (m_s2 && !(core_req || dma_req || pair_lock) && !excl) ? 2 : 0;
                2: if (!m_s2) m_st <= 3;
                default: m_st <= 0;
            endcase
        end
    end

    function automatic logic exp_gnt(); return m_st == 2; endfunction
    function automatic logic exp_drv(); return m_st == 0; endfunction
    function automatic logic exp_stall(); return core_req && (m_st != 0); endfunction
    function automatic logic exp_hold(); return (core_req || dma_req) && (m_st != 0); endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(); @(negedge clk); endtask
    task automatic settle(); #2; endtask
    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<100000", cycles);
            summary();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R1 reset state
        idle_cycles(3); settle();
        chk("R1", "gnt in reset", gnt, 0);
        chk("R1", "drv in reset", drv_en, 1);
        chk("R1", "stall in reset", stall, 0);
        chk("R1", "holdoff in reset", holdoff, 0);
        rst_n = 1;
        step(); settle();
        chk("R1", "gnt after reset", gnt, 0);
        chk("R1", "drv after reset", drv_en, 1);

        // R2/R3 isolated request latency
        step(); ext_req = 1; settle();
        chk("R2", "gnt before edge k", gnt, 0);
        step(); settle(); chk("R2", "drv after k", drv_en, 1);
        step(); settle(); chk("R2", "drv after k+1", drv_en, 1);
        step(); settle(); chk("R3", "drv after k+2", drv_en, 0);
        chk("R2", "gnt after k+2", gnt, 0);
        step(); settle(); chk("R2", "gnt after k+3", gnt, 1);
        chk("R3", "drv during grant", drv_en, 0);
        // R6 stall and holdoff, R7 no revoke
        core_req = 1; settle();
        chk("R6", "stall core during grant", stall, 1);
        chk("R6", "holdoff core during grant", holdoff, 1);
        step(); settle(); chk("R7", "gnt kept with core req", gnt, 1);
        core_req = 0; dma_req = 1; settle();
        chk("R6", "stall dma only", stall, 0);
        chk("R6", "holdoff dma only", holdoff, 1);
        step(); settle(); chk("R7", "gnt kept with dma req", gnt, 1);
        // R8 release
        dma_req = 0; ext_req = 0;
        step(); settle(); chk("R8", "gnt after m", gnt, 1);
        step(); settle(); chk("R8", "gnt after m+1", gnt, 1);
        step(); settle(); chk("R8", "gnt after m+2", gnt, 0);
        chk("R8", "drv after m+2", drv_en, 0);
        step(); settle(); chk("R8", "drv after m+3", drv_en, 1);

        // R4 internal priority
        core_req = 1; ext_req = 1;
        for (int i = 0; i < 6; i++) begin
            step(); settle();
            chk("R4", "gnt blocked by core", gnt, 0);
            chk("R4", "drv held by core", drv_en, 1);
        end
        dma_req = 1; core_req = 0;
        for (int i = 0; i < 3; i++) begin
            step(); settle(); chk("R4", "gnt blocked by dma", gnt, 0);
        end
        dma_req = 0;
        step(); settle(); chk("R4", "drv off after clear", drv_en, 0);
        chk("R4", "gnt not yet", gnt, 0);
        step(); settle(); chk("R4", "gnt after clear", gnt, 1);
        ext_req = 0; idle_cycles(5); settle();
        chk("R8", "drv back", drv_en, 1);

        // R5 atomic pair lock then read-write gap
        pair_lock = 1; ext_req = 1;
        for (int i = 0; i < 6; i++) begin
            step(); settle(); chk("R5", "gnt blocked by pair lock", gnt, 0);
        end
        core_req = 1; step(); core_req = 0; pair_lock = 0;
        step(); settle(); chk("R5", "drv off in read-write gap", drv_en, 0);
        step(); settle(); chk("R5", "gnt in read-write gap", gnt, 1);
        ext_req = 0; idle_cycles(5);

        // R9 exclusive mode
        excl = 1; ext_req = 1;
        for (int i = 0; i < 8; i++) begin
            step(); settle();
            chk("R9", "gnt blocked by excl", gnt, 0);
            chk("R9", "drv kept by excl", drv_en, 1);
        end
        excl = 0;
        step(); settle(); chk("R9", "drv off after excl clear", drv_en, 0);
        step(); settle(); chk("R9", "gnt after excl clear", gnt, 1);
        ext_req = 0; idle_cycles(5);

        // R10 cancel during drivers-off cycle
        ext_req = 1;
        idle_cycles(3); settle();
        chk("R10", "drv off before cancel", drv_en, 0);
        core_req = 1; settle();
        chk("R6", "stall in float cycle", stall, 1);
        step(); settle();
        chk("R10", "gnt after cancel", gnt, 0);
        chk("R10", "drv after cancel", drv_en, 1);
        core_req = 0;
        step(); settle(); chk("R10", "drv off retry", drv_en, 0);
        step(); settle(); chk("R10", "gnt retry", gnt, 1);
        ext_req = 0; idle_cycles(5);

        // random mix against model
        for (int i = 0; i < 4000; i++) begin
            step();
            if ($urandom_range(7) == 0) ext_req = ~ext_req;
            core_req  = ($urandom_range(3) == 0);
            dma_req   = ($urandom_range(5) == 0);
            if ($urandom_range(9) == 0) pair_lock = ~pair_lock;
            if ($urandom_range(63) == 0) excl = ~excl;
            settle();
            chk("R2", "random gnt", gnt, exp_gnt());
            chk("R8", "random drv", drv_en, exp_drv());
            chk("R6", "random stall", stall, exp_stall());
            chk("R6", "random holdoff", holdoff, exp_hold());
        end
        summary();
    end
endmodule